// File: doc/BRIEF.md
# Resource-Driven Reloadable Event Counter

This block is a down-counter for a debug or trace unit. In each cycle in which a chosen trigger resource is active, the count drops by one. The count is restored from a programmed reload value when a second, separately chosen resource fires. An optional self-reload restarts the count when it has run down to zero and the count resource is active again.

Each of the two resources can be one of the single resource lines or one of the pair results, which are built outside this block. A configuration word picks both resources. A reload-value word holds the start value. Both words sit behind a small write/read register port. The count and a zero flag are outputs, so trace logic can react when the counter expires.

Top module: `rsc_event_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count is cleared to 0, the configuration word and the reload value are cleared, and `zero_o` is 1.
- R2: The configuration word sits at address 0. Its fields are: count selector [3:0], count type [7], reload selector [11:8], reload type [15] and self-reload enable [16]. All other bits ignore writes and read as 0, so writing 0xFFFFFFFF reads back 0x00018F8F.
- R3: The reload value sits at address 1 in bits [15:0], and its upper bits read as 0. Writing it leaves the current count unchanged.
- R4: With a type bit of 0, the resource is `single_i[sel]`, using all 4 selector bits.
- R5: With a type bit of 1, the resource is `pair_i[sel[2:0]]`. Selector bit 3 is ignored.
- R6: When the count resource is active, the count is nonzero and no reload occurs, the count drops by exactly 1 at the next edge.
- R7: At zero and with no reload, the count holds at 0 whatever the count resource does.
- R8: When the reload resource is active, the count takes the reload value at the next edge.
- R9: With self-reload enabled, a count of 0 together with an active count resource reloads the count. With self-reload disabled, that condition does not reload.
- R10: When a reload and a decrement condition hold in the same cycle, the reload wins.
- R11: `zero_o` is 1 exactly when the count is 0, in the same cycle.
- R12: Writes to addresses other than 0 and 1 have no effect, and reads there return 0. A written word governs counting from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_i | input | 16 | Single resource lines |
| pair_i | input | 8 | Combined pair results |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| count_o | output | 16 | Current count |
| zero_o | output | 1 | Count equals zero |

## Verification
The bench builds the block with its default parameters: 16 single lines, 8 pair lines and a 16-bit count. At these sizes, every selector code, including the pair codes with bit 3 set, is reachable within a few thousand random cycles. Small reload values are drawn on purpose, so the count often reaches zero and the self-reload and hold-at-zero paths are exercised. A bench model is compared against the count every cycle, and directed phases cover the read-back masking and the ignored addresses.

// File: rtl/rsc_counter_pkg.sv
// Package: field positions of the configuration word and the register addresses.
// Assumes the fixed layout given in the brief; widths of data paths are module parameters.
package rsc_counter_pkg;
    localparam int CFG_W        = 32;
    localparam int SEL_W        = 4;
    localparam int CNT_SEL_LSB  = 0;
    localparam int CNT_TYPE_BIT = 7;
    localparam int RLD_SEL_LSB  = 8;
    localparam int RLD_TYPE_BIT = 15;
    localparam int SELF_RLD_BIT = 16;
    localparam logic [CFG_W-1:0] CFG_MASK = 32'h0001_8F8F;

    typedef enum logic [1:0] {
        ADDR_CFG = 2'd0,
        ADDR_RLD = 2'd1
    } reg_addr_e;

    typedef struct packed {
        logic             self_rld;
        logic             rld_type;
        logic [SEL_W-1:0] rld_sel;
        logic             cnt_type;
        logic [SEL_W-1:0] cnt_sel;
    } cfg_t;
endpackage

// File: rtl/rsc_select.sv
// Resource selector: picks one single line or one pair result.
// Assumes N_PAIR <= 2**SEL_W; pair mode uses only the low PAIR_W selector bits.
module rsc_select #(
    parameter int N_SINGLE = 16,
    parameter int N_PAIR   = 8,
    parameter int SEL_W    = 4
) (
    input  logic                is_pair_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [N_SINGLE-1:0] single_i,
    input  logic [N_PAIR-1:0]   pair_i,
    output logic                hit_o
);
    localparam int PAIR_W = (N_PAIR > 1) ? $clog2(N_PAIR) : 1;

    logic single_hit;
    logic pair_hit;

    // Pick a single line; out-of-range codes select nothing.
    always_comb begin
        single_hit = 1'b0;
        for (int i = 0; i < N_SINGLE; i++) begin
            if (sel_i == SEL_W'(i)) single_hit = single_i[i];
        end
    end

    // Pick a pair result from the low selector bits only.
    always_comb begin
        pair_hit = 1'b0;
        for (int j = 0; j < N_PAIR; j++) begin
            if (sel_i[PAIR_W-1:0] == PAIR_W'(j)) pair_hit = pair_i[j];
        end
    end

    // Choose between single and pair by the type bit.
    assign hit_o = is_pair_i ? pair_hit : single_hit;
endmodule

// File: rtl/rsc_cfg_regs.sv
// Register file: configuration word and reload value behind a write/read port.
// Assumes writes land at the rising edge; reads are combinational; reserved bits are not stored.
module rsc_cfg_regs
    import rsc_counter_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CFG_W-1:0]  rd_data_o,
    output cfg_t              cfg_o,
    output logic [CNT_W-1:0]  rld_val_o
);
    cfg_t             cfg_q;
    logic [CNT_W-1:0] rld_q;

    // Store only the defined configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CFG)) begin
            cfg_q.self_rld <= wr_data_i[SELF_RLD_BIT];
            cfg_q.rld_type <= wr_data_i[RLD_TYPE_BIT];
            cfg_q.rld_sel  <= wr_data_i[RLD_SEL_LSB +: SEL_W];
            cfg_q.cnt_type <= wr_data_i[CNT_TYPE_BIT];
            cfg_q.cnt_sel  <= wr_data_i[CNT_SEL_LSB +: SEL_W];
        end
    end

    // Store the reload value from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_RLD)) begin
            rld_q <= wr_data_i[CNT_W-1:0];
        end
    end

    // Assemble read data; reserved bits and unmapped addresses give zero.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADDR_CFG)) begin
            rd_data_o[SELF_RLD_BIT]             = cfg_q.self_rld;
            rd_data_o[RLD_TYPE_BIT]             = cfg_q.rld_type;
            rd_data_o[RLD_SEL_LSB +: SEL_W]     = cfg_q.rld_sel;
            rd_data_o[CNT_TYPE_BIT]             = cfg_q.cnt_type;
            rd_data_o[CNT_SEL_LSB +: SEL_W]     = cfg_q.cnt_sel;
        end else if (rd_addr_i == ADDR_W'(ADDR_RLD)) begin
            rd_data_o[CNT_W-1:0] = rld_q;
        end
    end

    assign cfg_o     = cfg_q;
    assign rld_val_o = rld_q;

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == ADDR_W'(ADDR_CFG)) |-> ((rd_data_o & ~CFG_MASK) == '0)); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i != ADDR_W'(ADDR_CFG) && rd_addr_i != ADDR_W'(ADDR_RLD)) |-> (rd_data_o == '0)); // R12
endmodule

// File: rtl/rsc_count_core.sv
// Count core: decrements on the count resource, reloads on the reload resource or on self-reload.
// Assumes the resource hits are already decoded; reload has priority over decrement.
module rsc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_hit_i,
    input  logic             rld_hit_i,
    input  logic             self_rld_i,
    input  logic [CNT_W-1:0] rld_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;
    logic             self_fire;
    logic             reload;

    assign at_zero   = (cnt_q == '0);
    assign self_fire = self_rld_i && at_zero && cnt_hit_i;
    assign reload    = rld_hit_i || self_fire;

    // Update the count: reload first, then decrement if allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= rld_val_i;
        end else if (cnt_hit_i && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = at_zero;

    AST_RLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rld_hit_i |=> (count_o == $past(rld_val_i))); // R8
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit_i && !rld_hit_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1)); // R6
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && !rld_hit_i && !self_rld_i) |=> (count_o == '0)); // R7
    AST_SELF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (self_rld_i && count_o == '0 && cnt_hit_i) |=> (count_o == $past(rld_val_i))); // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_hit_i && !rld_hit_i) |=> $stable(count_o)); // R6
endmodule

// File: rtl/rsc_event_counter.sv
// Top: resource-driven reloadable down-counter with its register port.
// Assumes resource lines are synchronous to clk; configuration takes effect the edge after a write.
module rsc_event_counter
    import rsc_counter_pkg::*;
#(
    parameter int N_SINGLE = 16,
    parameter int N_PAIR   = 8,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SINGLE-1:0] single_i,
    input  logic [N_PAIR-1:0]   pair_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [CFG_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic [CFG_W-1:0]    rd_data_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                zero_o
);
    cfg_t             cfg;
    logic [CNT_W-1:0] rld_val;
    logic             cnt_hit;
    logic             rld_hit;

    rsc_cfg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .cfg_o     (cfg),
        .rld_val_o (rld_val)
    );

    rsc_select #(.N_SINGLE(N_SINGLE), .N_PAIR(N_PAIR), .SEL_W(SEL_W)) u_cnt_sel (
        .is_pair_i (cfg.cnt_type),
        .sel_i     (cfg.cnt_sel),
        .single_i  (single_i),
        .pair_i    (pair_i),
        .hit_o     (cnt_hit)
    );

    rsc_select #(.N_SINGLE(N_SINGLE), .N_PAIR(N_PAIR), .SEL_W(SEL_W)) u_rld_sel (
        .is_pair_i (cfg.rld_type),
        .sel_i     (cfg.rld_sel),
        .single_i  (single_i),
        .pair_i    (pair_i),
        .hit_o     (rld_hit)
    );

    rsc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_hit_i  (cnt_hit),
        .rld_hit_i  (rld_hit),
        .self_rld_i (cfg.self_rld),
        .rld_val_i  (rld_val),
        .count_o    (count_o),
        .zero_o     (zero_o)
    );

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (count_o == '0)); // R11
endmodule

// File: tb/test_rsc_event_counter.sv
module test_rsc_event_counter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] single_i;
    logic [7:0]  pair_i;
    logic        wr_en_i;
    logic [1:0]  wr_addr_i;
    logic [31:0] wr_data_i;
    logic [1:0]  rd_addr_i;
    logic [31:0] rd_data_o;
    logic [15:0] count_o;
    logic        zero_o;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned wd    = 0;

    // model state
    logic [31:0] m_cfg;
    logic [15:0] m_rld;
    logic [15:0] m_cnt;

    always #4 clk = ~clk; // 125 MHz

    rsc_event_counter i_rsc_event_counter (
        .clk(clk), .rst_n(rst_n), .single_i(single_i), .pair_i(pair_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .count_o(count_o), .zero_o(zero_o)
    );

    function automatic logic pick(logic is_pair, logic [3:0] sel, logic [15:0] s, logic [7:0] p);
        return is_pair ? p[sel[2:0]] : s[sel];
    endfunction

    function automatic logic [15:0] next_cnt(logic [31:0] cfg, logic [15:0] rv, logic [15:0] c,
                                             logic [15:0] s, logic [7:0] p);
        logic ch, rh;
        ch = pick(cfg[7], cfg[3:0], s, p);
        rh = pick(cfg[15], cfg[11:8], s, p);
        if (rh || (cfg[16] && c == 0 && ch)) return rv;
        if (ch && c != 0) return c - 16'd1;
        return c;
    endfunction

    function automatic string tag_of(logic [31:0] cfg, logic [15:0] c, logic [15:0] s, logic [7:0] p);
        logic ch, rh;
        ch = pick(cfg[7], cfg[3:0], s, p);
        rh = pick(cfg[15], cfg[11:8], s, p);
        if (rh && ch && c != 0) return "R10";
        if (rh) return "R8";
        if (cfg[16] && c == 0 && ch) return "R9";
        if (c == 0) return "R7";
        return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one clock: model the edge, then compare after it
    task automatic cycle();
        logic [15:0] nc;
        string tg;
        nc = next_cnt(m_cfg, m_rld, m_cnt, single_i, pair_i);
        tg = tag_of(m_cfg, m_cnt, single_i, pair_i);
        @(posedge clk);
        m_cnt = nc;
        if (wr_en_i && wr_addr_i == 2'd0) m_cfg = wr_data_i & 32'h0001_8F8F;
        if (wr_en_i && wr_addr_i == 2'd1) m_rld = wr_data_i[15:0];
        @(negedge clk);
        wr_en_i = 1'b0;
        check(tg, {16'd0, count_o}, {16'd0, m_cnt});
        check("R11", {31'd0, zero_o}, {31'd0, (count_o == 16'd0)});
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        cycle();
    endtask

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; single_i = '0; pair_i = '0;
        wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
        m_cfg = '0; m_rld = '0; m_cnt = '0;
        single_i = 16'hFFFF; pair_i = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {16'd0, count_o}, 32'd0);
        check("R1", {31'd0, zero_o}, 32'd1);
        rd_addr_i = 2'd0; #1 check("R1", rd_data_o, 32'd0);
        rd_addr_i = 2'd1; #1 check("R1", rd_data_o, 32'd0);
        rst_n = 1'b1; single_i = '0; pair_i = '0;

        // R2: reserved bits masked
        wr(2'd0, 32'hFFFF_FFFF);
        rd_addr_i = 2'd0; #1 check("R2", rd_data_o, 32'h0001_8F8F);
        // R3: reload value read back, count unchanged
        wr(2'd1, 32'hABCD_1234);
        rd_addr_i = 2'd1; #1 check("R3", rd_data_o, 32'h0000_1234);
        check("R3", {16'd0, count_o}, 32'd0);
        // R12: unmapped address ignored
        wr(2'd2, 32'h5555_5555);
        rd_addr_i = 2'd2; #1 check("R12", rd_data_o, 32'd0);
        rd_addr_i = 2'd0; #1 check("R12", rd_data_o, 32'h0001_8F8F);
        rd_addr_i = 2'd1; #1 check("R12", rd_data_o, 32'h0000_1234);

        // R4: single select 5 counts, reload on single 9
        wr(2'd0, 32'h0000_0905);
        single_i = 16'h0200; cycle();
        check("R8", {16'd0, count_o}, 32'h1234);
        single_i = 16'h0020; cycle();
        check("R4", {16'd0, count_o}, 32'h1233);
        single_i = 16'hFDDF; cycle();
        check("R4", {16'd0, count_o}, 32'h1233);
        // R10: reload and count together
        single_i = 16'h0220; cycle();
        check("R10", {16'd0, count_o}, 32'h1234);

        // R5: pair select code 0xB -> pair 3, reload pair 6 (code 0xE)
        single_i = '0;
        wr(2'd0, 32'h0000_8E8B);
        pair_i = 8'h08; cycle();
        check("R5", {16'd0, count_o}, 32'h1233);
        pair_i = 8'hB7; cycle();
        check("R5", {16'd0, count_o}, 32'h1233);
        pair_i = 8'h40; cycle();
        check("R5", {16'd0, count_o}, 32'h1234);

        // R9 / R7: run to zero from 2
        pair_i = '0;
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h0000_0003);   // count single 3, reload single 0, no self
        single_i = 16'h0001; cycle();
        single_i = 16'h0008; cycle(); cycle();
        check("R6", {16'd0, count_o}, 32'd0);
        cycle();
        check("R7", {16'd0, count_o}, 32'd0);
        single_i = '0;
        wr(2'd0, 32'h0001_0003);
        single_i = 16'h0008; cycle();
        check("R9", {16'd0, count_o}, 32'd2);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            single_i = 16'($urandom);
            pair_i   = 8'($urandom);
            if (r[3:0] == 4'd0) begin
                wr_en_i = 1'b1; wr_addr_i = 2'($urandom);
                wr_data_i = (r[4]) ? 32'($urandom % 6) : $urandom;
            end
            rd_addr_i = 2'($urandom);
            cycle();
            #1;
            case (rd_addr_i)
                2'd0: check("R2", rd_data_o, m_cfg);
                2'd1: check("R3", rd_data_o, {16'd0, m_rld});
                default: check("R12", rd_data_o, 32'd0);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule